// File: doc/BRIEF.md
# EEPROM Transaction Sequencer

This block runs whole serial-EEPROM transactions on top of a byte-level two-wire master engine. A client hands over one request: a 7-bit device address, a one-byte word address, a length of 1 to 256 bytes and a direction. The sequencer then drives the engine through the complete exchange. It requests the start condition, loads the address byte, sends the word address and moves the data bytes. It ends the exchange with a stop and a done pulse.

Writes send the word address and then stream bytes taken from a pop-style byte source. Reads send the word address as a write and issue a repeated start. They then readdress the device for reading and deliver each received byte on a strobed output, with ACK returned on every byte except the final one. When a request enables acknowledge polling, a NACK on an address or word-address byte triggers a fresh start. This lets a client wait out an EEPROM's internal write cycle. Any other failure resets the engine and ends the transaction with an error.

All command outputs are registered. They appear in the cycle after the request or event that causes them.

Top module: `eeprom_txn_seq`

## Requirements
- R1: A request is taken only while `req_ready_o` is high, which is exactly when `busy_o` is low. In the cycle after acceptance, `busy_o` is high and `eng_start_o` pulses. While busy, `req_ready_o` stays low and further requests are not taken.
- R2: On event code 0 (start sent), the sequencer pulses `eng_load_o` with `eng_tx_o` = {device address in bits 7:1, R/W in bit 0}. R/W is 0 for the first addressing of every transaction and 1 after a read's repeated start.
- R3: In a read, the word address is loaded after the ACK of the write-mode address byte. After the word address is ACKed, a repeated start is requested and the address byte is resent with bit 0 = 1.
- R4: In a write, after the word address is ACKed, each ACKed byte (event code 1 with `evt_ack_i`=1) loads the next byte from `wr_data_i` together with a one-cycle `wr_pop_o`. The ACK of the final byte yields `eng_stop_o`, and `done_o` is set with `err_o` low.
- R5: `done_o` is a one-cycle pulse at the end of each transaction. `err_o` is high only in that cycle and only for a failed transaction, and `busy_o` is low from that cycle on.
- R6: `req_len_i` holds the byte count minus one, so 0 means 1 byte and 255 means 256 bytes. Exactly that many data bytes are moved, never more.
- R7: In a read, each event code 2 (byte received) yields a `rd_valid_o` pulse with the byte on `rd_data_o`. `eng_ack_o` is 1 while a non-final byte is being received and 0 while the final one is, and the final byte also yields `eng_stop_o`. `eng_start_o` and `eng_stop_o` never pulse together.
- R8: With `req_poll_i` set, a NACK (event code 1, `evt_ack_i`=0) on an address byte or on the word address leads to a new `eng_start_o`. The whole addressing is repeated, with no retry limit.
- R9: Three conditions end the transaction as a failure: a NACK with polling off, a NACK on a data byte, or an event code the current step does not expect (including code 3). A failure pulses `eng_rst_o` together with `done_o` and `err_o`, and returns the sequencer to idle.
- R10: Events arriving while idle cause no command, no data strobe and no change of `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transaction request |
| req_ready_o | output | 1 | Request can be taken |
| req_dev_i | input | 7 | Device address |
| req_word_i | input | 8 | Word address inside the EEPROM |
| req_len_i | input | 8 | Byte count minus one |
| req_read_i | input | 1 | 1 = random read, 0 = write |
| req_poll_i | input | 1 | Restart on address NACK |
| wr_data_i | input | 8 | Next write byte, held until popped |
| wr_pop_o | output | 1 | Write byte consumed |
| rd_valid_o | output | 1 | Read byte strobe |
| rd_data_o | output | 8 | Read byte |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | End-of-transaction pulse |
| err_o | output | 1 | Transaction failed (with done) |
| eng_start_o | output | 1 | Ask engine for (repeated) start |
| eng_stop_o | output | 1 | Ask engine for stop |
| eng_load_o | output | 1 | Load byte for transmission |
| eng_tx_o | output | 8 | Byte to transmit |
| eng_ack_o | output | 1 | ACK level for the byte being received |
| eng_rst_o | output | 1 | Disable and re-enable the engine |
| evt_valid_i | input | 1 | Engine event strobe |
| evt_code_i | input | 2 | 0 start sent, 1 byte sent, 2 byte received, 3 other |
| evt_ack_i | input | 1 | ACK seen on transmitted byte |
| evt_data_i | input | 8 | Received byte |

## Verification
A table walks writes and reads of one byte and of four bytes. Some run with zero address NACKs and some with several, on two device addresses and on a word address that wraps past 0xFF. Writing a range and reading it back shows that the word address, the data order and the pop sequence all agree. The number of starts observed tells the plain case apart from the polled retries and the read's repeated start. Directed cases separate the three failure causes from one another and from normal ends. They also cover a full 256-byte read at the length limit, and events presented while idle.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  typedef enum logic [1:0] {
    EV_START = 2'd0,
    EV_TX    = 2'd1,
    EV_RX    = 2'd2,
    EV_OTHER = 2'd3
  } evt_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_ADDR,
    PH_WORD,
    PH_DATA,
    PH_RX
  } phase_e;
endpackage

// File: rtl/seq_len_counter.sv
module seq_len_counter #(
  parameter int LEN_W = 8,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] len_m1_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = cnt_q == {1'b0, len_m1_i};
  assign full_o = cnt_q == ({1'b0, len_m1_i} + CNT_W'(1));

  // R6: never counts past the requested length
  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !full_o);
endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
  import eeprom_seq_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8,
  localparam int CNT_W = LEN_W + 1,
  localparam int DEV_W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [DEV_W-1:0]  req_dev_i,
  input  logic [DATA_W-1:0] req_word_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_read_i,
  input  logic              req_poll_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_pop_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              eng_start_o,
  output logic              eng_stop_o,
  output logic              eng_load_o,
  output logic [DATA_W-1:0] eng_tx_o,
  output logic              eng_ack_o,
  output logic              eng_rst_o,
  input  logic              evt_valid_i,
  input  logic [1:0]        evt_code_i,
  input  logic              evt_ack_i,
  input  logic [DATA_W-1:0] evt_data_i,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o,
  output logic [LEN_W-1:0]  len_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cnt_last_i,
  input  logic              cnt_full_i
);
  phase_e            phase_q, phase_d;
  logic [DEV_W-1:0]  dev_q;
  logic [DATA_W-1:0] word_q;
  logic [LEN_W-1:0]  len_q;
  logic              rd_q, poll_q, rw_q, rw_d, wsent_q, wsent_d;
  logic [DATA_W-1:0] tx_q, tx_d, rdd_q, rdd_d;
  logic              ack_q, ack_d;
  logic              start_q, start_d, stop_q, stop_d, load_q, load_d;
  logic              pop_q, pop_d, rdv_q, rdv_d, done_q, done_d, err_q, err_d, erst_q, erst_d;
  logic              latch, nack, wr_next, finish, fail;
  evt_e              evt;

  assign evt = evt_e'(evt_code_i);

  always_comb begin
    phase_d = phase_q; rw_d = rw_q; wsent_d = wsent_q; tx_d = tx_q; rdd_d = rdd_q; ack_d = ack_q;
    start_d = 1'b0; stop_d = 1'b0; load_d = 1'b0; pop_d = 1'b0; rdv_d = 1'b0;
    done_d = 1'b0; err_d = 1'b0; erst_d = 1'b0;
    latch = 1'b0; nack = 1'b0; wr_next = 1'b0; finish = 1'b0; fail = 1'b0;
    cnt_clr_o = 1'b0; cnt_inc_o = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (req_valid_i) begin
        latch = 1'b1; start_d = 1'b1; phase_d = PH_START;
        rw_d = 1'b0; wsent_d = 1'b0; ack_d = 1'b1; cnt_clr_o = 1'b1;
      end
    end else if (evt_valid_i) begin
      unique case (phase_q)
        PH_START:
          if (evt == EV_START) begin
            tx_d = {dev_q, rw_q}; load_d = 1'b1; cnt_clr_o = 1'b1; phase_d = PH_ADDR;
          end else fail = 1'b1;
        PH_ADDR:
          if (evt != EV_TX) fail = 1'b1;
          else if (!evt_ack_i) nack = 1'b1;
          else if (!wsent_q) begin
            tx_d = word_q; load_d = 1'b1; wsent_d = 1'b1; phase_d = PH_WORD;
          end else if (rw_q) begin
            phase_d = PH_RX; ack_d = !cnt_last_i;
          end else wr_next = 1'b1;
        PH_WORD:
          if (evt != EV_TX) fail = 1'b1;
          else if (!evt_ack_i) begin
            nack = 1'b1; wsent_d = 1'b0; rw_d = 1'b0;
          end else if (rd_q) begin
            rw_d = 1'b1; start_d = 1'b1; phase_d = PH_START;
          end else wr_next = 1'b1;
        PH_DATA:
          if (evt != EV_TX || !evt_ack_i) fail = 1'b1;
          else wr_next = 1'b1;
        PH_RX:
          if (evt != EV_RX) fail = 1'b1;
          else begin
            rdv_d = 1'b1; rdd_d = evt_data_i; cnt_inc_o = 1'b1;
            if (cnt_last_i) begin stop_d = 1'b1; finish = 1'b1; end
            else ack_d = (cnt_i + CNT_W'(1)) != {1'b0, len_q};
          end
        default: fail = 1'b1;
      endcase
      if (wr_next) begin
        if (!cnt_full_i) begin
          tx_d = wr_data_i; load_d = 1'b1; pop_d = 1'b1; cnt_inc_o = 1'b1; phase_d = PH_DATA;
        end else begin
          stop_d = 1'b1; finish = 1'b1;
        end
      end
      if (nack) begin
        if (poll_q) begin start_d = 1'b1; phase_d = PH_START; end
        else fail = 1'b1;
      end
      if (finish) begin
        done_d = 1'b1; phase_d = PH_IDLE; ack_d = 1'b1;
      end
      if (fail) begin
        erst_d = 1'b1; err_d = 1'b1; done_d = 1'b1; phase_d = PH_IDLE; ack_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE; dev_q <= '0; word_q <= '0; len_q <= '0;
      rd_q <= 1'b0; poll_q <= 1'b0; rw_q <= 1'b0; wsent_q <= 1'b0;
      tx_q <= '0; rdd_q <= '0; ack_q <= 1'b1;
      start_q <= 1'b0; stop_q <= 1'b0; load_q <= 1'b0; pop_q <= 1'b0; rdv_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; erst_q <= 1'b0;
    end else begin
      if (latch) begin
        dev_q <= req_dev_i; word_q <= req_word_i; len_q <= req_len_i;
        rd_q <= req_read_i; poll_q <= req_poll_i;
      end
      phase_q <= phase_d; rw_q <= rw_d; wsent_q <= wsent_d;
      tx_q <= tx_d; rdd_q <= rdd_d; ack_q <= ack_d;
      start_q <= start_d; stop_q <= stop_d; load_q <= load_d; pop_q <= pop_d; rdv_q <= rdv_d;
      done_q <= done_d; err_q <= err_d; erst_q <= erst_d;
    end
  end

  assign busy_o      = phase_q != PH_IDLE;
  assign req_ready_o = phase_q == PH_IDLE;
  assign len_o       = len_q;
  assign wr_pop_o    = pop_q;
  assign rd_valid_o  = rdv_q;
  assign rd_data_o   = rdd_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign eng_start_o = start_q;
  assign eng_stop_o  = stop_q;
  assign eng_load_o  = load_q;
  assign eng_tx_o    = tx_q;
  assign eng_ack_o   = ack_q;
  assign eng_rst_o   = erst_q;

  a_r1_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (busy_o && eng_start_o));
  a_r3_restart_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WORD && evt_valid_i && evt == EV_TX && evt_ack_i && rd_q) |=> eng_start_o);
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && !busy_o));
  a_r7_nack_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RX && evt_valid_i && evt == EV_RX && cnt_last_i) |-> !eng_ack_o);
  a_r7_start_stop_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eng_start_o && eng_stop_o));
  a_r9_reset_is_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_rst_o |-> err_o);
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_valid_i) |=> !(eng_load_o || eng_start_o || rd_valid_o || busy_o));
endmodule

// File: rtl/eeprom_txn_seq.sv
module eeprom_txn_seq #(
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8,
  localparam int CNT_W = LEN_W + 1,
  localparam int DEV_W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [DEV_W-1:0]  req_dev_i,
  input  logic [DATA_W-1:0] req_word_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_read_i,
  input  logic              req_poll_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_pop_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              eng_start_o,
  output logic              eng_stop_o,
  output logic              eng_load_o,
  output logic [DATA_W-1:0] eng_tx_o,
  output logic              eng_ack_o,
  output logic              eng_rst_o,
  input  logic              evt_valid_i,
  input  logic [1:0]        evt_code_i,
  input  logic              evt_ack_i,
  input  logic [DATA_W-1:0] evt_data_i
);
  logic             cnt_clr, cnt_inc, cnt_last, cnt_full;
  logic [LEN_W-1:0] len;
  logic [CNT_W-1:0] cnt;

  seq_len_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(cnt_clr), .inc_i(cnt_inc), .len_m1_i(len),
    .cnt_o(cnt), .last_o(cnt_last), .full_o(cnt_full)
  );

  seq_ctrl_fsm #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_dev_i, .req_word_i, .req_len_i,
    .req_read_i, .req_poll_i, .wr_data_i, .wr_pop_o, .rd_valid_o, .rd_data_o,
    .busy_o, .done_o, .err_o, .eng_start_o, .eng_stop_o, .eng_load_o, .eng_tx_o,
    .eng_ack_o, .eng_rst_o, .evt_valid_i, .evt_code_i, .evt_ack_i, .evt_data_i,
    .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc), .len_o(len), .cnt_i(cnt),
    .cnt_last_i(cnt_last), .cnt_full_i(cnt_full)
  );
endmodule

// File: tb/sim_eeprom_txn_seq.sv
module sim_eeprom_txn_seq;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [6:0] dev;
    logic [7:0] word;
    logic [7:0] lenm1;
    logic       rd;
    logic [3:0] nacks;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{7'h50, 8'h10, 8'd3, 1'b0, 4'd0},
    '{7'h50, 8'h10, 8'd3, 1'b1, 4'd0},
    '{7'h50, 8'hFE, 8'd3, 1'b0, 4'd3},
    '{7'h51, 8'hFE, 8'd3, 1'b1, 4'd2},
    '{7'h50, 8'h40, 8'd0, 1'b0, 4'd1},
    '{7'h50, 8'h40, 8'd0, 1'b1, 4'd0}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_read = 0, req_poll = 0;
  logic [6:0] req_dev = '0;
  logic [7:0] req_word = '0, req_len = '0, wr_data = '0;
  logic evt_valid = 0, evt_ack = 0;
  logic [1:0] evt_code = '0;
  logic [7:0] evt_data = '0;
  logic req_ready, wr_pop, rd_valid, busy, done, err;
  logic eng_start, eng_stop, eng_load, eng_ack, eng_rst;
  logic [7:0] rd_data, eng_tx;

  int n_chk = 0, n_fail = 0, cyc = 0, widx = 0;
  logic [7:0] mem [256];

  always #(CLK_P/2) clk = ~clk;

  eeprom_txn_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_dev_i(req_dev), .req_word_i(req_word), .req_len_i(req_len),
    .req_read_i(req_read), .req_poll_i(req_poll), .wr_data_i(wr_data), .wr_pop_o(wr_pop),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .busy_o(busy), .done_o(done), .err_o(err),
    .eng_start_o(eng_start), .eng_stop_o(eng_stop), .eng_load_o(eng_load),
    .eng_tx_o(eng_tx), .eng_ack_o(eng_ack), .eng_rst_o(eng_rst),
    .evt_valid_i(evt_valid), .evt_code_i(evt_code), .evt_ack_i(evt_ack), .evt_data_i(evt_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 13 + 29);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step_evt(input logic [1:0] code, input logic ack, input logic [7:0] d);
    @(negedge clk);
    evt_valid = 1; evt_code = code; evt_ack = ack; evt_data = d;
    @(posedge clk); #1;
    evt_valid = 0;
  endtask

  task automatic issue(input logic [6:0] dev, input logic [7:0] word, input logic [7:0] lenm1,
                       input logic rd, input logic poll);
    @(negedge clk);
    req_valid = 1; req_dev = dev; req_word = word; req_len = lenm1; req_read = rd; req_poll = poll;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  // byte-event EEPROM model; kind: 0 addr, 1 word, 2 data
  task automatic run_txn(input vec_t v);
    int nleft = v.nacks, starts = 0, kind = 0, ridx = 0, guard = 0, wcnt = 0;
    bit got_word = 0, fin = 0, stop_seen = 0;
    logic [7:0] ptr = '0;
    wr_data = pat(widx);
    issue(v.dev, v.word, v.lenm1, v.rd, 1'b1);
    chk(eng_start && busy && !req_ready, "R1 accept", {eng_start, busy, req_ready}, 3'b110);
    while (!fin && guard < 2000) begin
      guard++;
      if (done) begin
        fin = 1;
      end else if (eng_start) begin
        starts++;
        step_evt(2'd0, 1'b0, 8'h00);
        chk(eng_load && eng_tx[7:1] == v.dev, "R2 address byte", eng_tx, {v.dev, 1'b0});
        chk(eng_tx[0] == (got_word && v.rd), "R3 rw bit", eng_tx[0], got_word && v.rd);
        kind = 0;
      end else if (eng_load) begin
        if (kind == 0) begin
          logic a;
          a = (nleft == 0);
          if (!a) nleft--;
          step_evt(2'd1, a, 8'h00);
          if (eng_load) kind = got_word ? 2 : 1;
        end else if (kind == 1) begin
          chk(eng_tx == v.word, "R3 word address", eng_tx, v.word);
          ptr = eng_tx; got_word = 1;
          step_evt(2'd1, 1'b1, 8'h00);
          kind = 2;
        end else begin
          mem[ptr] = eng_tx; ptr++;
          step_evt(2'd1, 1'b1, 8'h00);
        end
        if (eng_load && kind == 2) begin
          chk(wr_pop && eng_tx == pat(widx), "R4 write byte", eng_tx, pat(widx));
          widx++; wcnt++; wr_data = pat(widx);
        end
        if (eng_stop) stop_seen = 1;
      end else if (busy) begin
        chk(eng_ack == (ridx != int'(v.lenm1)), "R7 ack level", eng_ack, ridx != int'(v.lenm1));
        step_evt(2'd2, 1'b0, mem[ptr]);
        chk(rd_valid && rd_data == mem[ptr], "R7 read byte", rd_data, mem[ptr]);
        ptr++; ridx++;
        if (eng_stop) stop_seen = 1;
      end else begin
        chk(0, "R5 ended without done", busy, 1);
        fin = 1;
      end
    end
    chk(done && !err && !busy, "R5 done no err", {done, err, busy}, 3'b100);
    chk(stop_seen, "R4 stop at end", stop_seen, 1);
    chk(starts == 1 + int'(v.nacks) + int'(v.rd), "R8 start count", starts, 1 + v.nacks + v.rd);
    chk((v.rd ? ridx : wcnt) == int'(v.lenm1) + 1, "R6 byte count", v.rd ? ridx : wcnt, v.lenm1 + 1);
    @(posedge clk); #1;
    chk(!done && !err, "R5 done one cycle", done, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && req_ready && !done && !err && eng_ack && !eng_load, "R1 reset state",
        {busy, req_ready, done, err}, 4'b0100);
    @(negedge clk); rst_n = 1;

    // R10: events while idle
    step_evt(2'd2, 1'b1, 8'hAA);
    chk(!rd_valid && !busy && !eng_load && !done, "R10 idle rx ignored", {rd_valid, busy}, 0);
    step_evt(2'd1, 1'b0, 8'h00);
    chk(!eng_start && !busy && !eng_rst && !done, "R10 idle tx ignored", {eng_start, busy}, 0);

    foreach (VECS[k]) run_txn(VECS[k]);

    // R6: full length read
    run_txn('{7'h52, 8'h00, 8'hFF, 1'b1, 4'd0});

    // R9: NACK with polling off, and R1 no second accept while busy
    issue(7'h50, 8'h00, 8'd0, 1'b0, 1'b0);
    @(negedge clk); req_valid = 1; req_dev = 7'h33;
    @(posedge clk); #1;
    chk(!req_ready && busy && !eng_start, "R1 busy refuses", req_ready, 0);
    req_valid = 0;
    step_evt(2'd0, 1'b0, 8'h00);
    chk(eng_tx == {7'h50, 1'b0}, "R1 kept first request", eng_tx, {7'h50, 1'b0});
    step_evt(2'd1, 1'b0, 8'h00);
    chk(eng_rst && err && done && !busy && !eng_start, "R9 nack no poll",
        {eng_rst, err, done, busy}, 4'b1110);

    // R9: unexpected event
    issue(7'h50, 8'h00, 8'd0, 1'b1, 1'b1);
    step_evt(2'd2, 1'b0, 8'h00);
    chk(eng_rst && err && done && !busy, "R9 unexpected code", {eng_rst, err, done, busy}, 4'b1110);
    issue(7'h50, 8'h00, 8'd0, 1'b1, 1'b1);
    step_evt(2'd3, 1'b0, 8'h00);
    chk(eng_rst && err && done && !busy, "R9 other code", {eng_rst, err, done, busy}, 4'b1110);

    // R9: data NACK fails even with polling
    wr_data = 8'h5C;
    issue(7'h50, 8'h20, 8'd1, 1'b0, 1'b1);
    step_evt(2'd0, 1'b0, 8'h00);
    step_evt(2'd1, 1'b1, 8'h00);
    step_evt(2'd1, 1'b1, 8'h00);
    chk(eng_load && wr_pop && eng_tx == 8'h5C, "R4 first data", eng_tx, 8'h5C);
    step_evt(2'd1, 1'b0, 8'h00);
    chk(eng_rst && err && done && !eng_start, "R9 data nack", {eng_rst, err, done}, 3'b111);

    // R8: word-address NACK with polling restarts addressing
    issue(7'h50, 8'h30, 8'd0, 1'b1, 1'b1);
    step_evt(2'd0, 1'b0, 8'h00);
    step_evt(2'd1, 1'b1, 8'h00);
    step_evt(2'd1, 1'b0, 8'h00);
    chk(eng_start && busy && !err, "R8 word nack restart", {eng_start, busy}, 2'b11);
    step_evt(2'd0, 1'b0, 8'h00);
    chk(eng_tx == {7'h50, 1'b0}, "R8 readdress as write", eng_tx, {7'h50, 1'b0});
    step_evt(2'd1, 1'b1, 8'h00);
    chk(eng_load && eng_tx == 8'h30, "R8 word resent", eng_tx, 8'h30);
    step_evt(2'd2, 1'b0, 8'h00);
    chk(err && done, "R9 rx during word", {err, done}, 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule